// File: doc/BRIEF.md
# Modem Control and Status Register

This block keeps the modem-control byte and the modem-status byte of a 16550-style serial port. Software writes the control byte to set four output levels (RTS, DTR and two general outputs) and a loopback switch. The four external modem lines (clear-to-send, data-set-ready, carrier-detect, ring) are synchronized, held in the status byte, and watched for changes. A change sets a sticky delta bit. For the ring line, only a falling edge sets its delta bit.

The delta bits are cleared on the cycle after a status read. An event that lands on that same cycle still survives the clear. When any delta is held, a single any-delta flag goes high for the interrupt logic. In loopback, the status byte is formed from the control bits, so driver software can test itself without a cable. The RTS and DTR pins are held inactive while loopback is on.

Top module: `mdm_ctl_stat`

## Requirements
- R1: After reset the control readback is 0x08 (only the general output 2 bit set), out2_o is 1, rts_o, dtr_o and out1_o are 0, the status readback is 0xB0 and any_delta_o is 0.
- R2: A control write stores wdata[4:0] and forces readback bits 7:5 to zero. Bit 4 is loopback, bit 3 drives out2_o, bit 2 drives out1_o, bit 1 drives rts_o and bit 0 drives dtr_o, all active high, from the cycle after the write.
- R3: Outside loopback, status bits 7..4 show carrier-detect, ring, data-set-ready and clear-to-send. A line change first shows three clock edges after it is applied: two synchronizer flops, then the status register.
- R4: A change in either direction of clear-to-send, data-set-ready or carrier-detect sets status bit 0, bit 1 or bit 3 respectively.
- R5: Status bit 2 is set when the ring line goes from 1 to 0 and is not set when it goes from 0 to 1.
- R6: Delta bits stay set until a status read outside loopback. The read returns them in the read cycle, and they are zero from the next cycle unless a new event arrives.
- R7: A delta event registered on the same clock edge as the clear from a read is kept, while the older deltas are cleared.
- R8: In loopback, the status readback is {out2, out1, dtr, rts, 4'b0000}. Its delta bits read zero, and a status read in loopback does not clear the held deltas.
- R9: In loopback, rts_o and dtr_o are 0 whatever the control bits hold; out1_o and out2_o still follow their control bits.
- R10: any_delta_o is 1 exactly when at least one held delta bit is set, in loopback as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln_cts_i | input | 1 | Clear-to-send line, 1 = asserted |
| ln_dsr_i | input | 1 | Data-set-ready line, 1 = asserted |
| ln_dcd_i | input | 1 | Carrier-detect line, 1 = asserted |
| ln_ri_i | input | 1 | Ring line, 1 = asserted |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control write data |
| ctl_rdata_o | output | 8 | Control byte readback |
| sts_rd_i | input | 1 | Status byte read strobe |
| sts_rdata_o | output | 8 | Status byte readback |
| rts_o | output | 1 | RTS level |
| dtr_o | output | 1 | DTR level |
| out1_o | output | 1 | General output 1 level |
| out2_o | output | 1 | General output 2 level |
| any_delta_o | output | 1 | At least one delta bit held |

## Verification
The assertions assume that a status read strobe lasts one cycle per read. They also assume the modem lines are ordinary levels whose synchronized value the status register samples every cycle, so one compare of old against new per edge is the whole change history. The stimulus keeps each read strobe to a single cycle and changes lines only on falling clock edges. Lines are held for at least the three-edge latency before the next check, except in the same-edge scenario, which times a read deliberately against a line change.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Line vector order: [3]=carrier, [2]=ring, [1]=data-set-ready, [0]=clear-to-send
  localparam int unsigned NLINE  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTL_W  = 5;

  localparam logic [NLINE-1:0]  LINE_RST = 4'b1011;
  localparam logic [BYTE_W-1:0] CTL_RST  = 8'h08;
  localparam logic [BYTE_W-1:0] CTL_MASK = 8'h1F;

  // Control bit positions
  localparam int unsigned B_DTR  = 0;
  localparam int unsigned B_RTS  = 1;
  localparam int unsigned B_OUT1 = 2;
  localparam int unsigned B_OUT2 = 3;
  localparam int unsigned B_LOOP = 4;

  // Delta bits raised by one registered line transition
  function automatic logic [NLINE-1:0] f_delta_set(input logic [NLINE-1:0] prev,
                                                   input logic [NLINE-1:0] nxt);
    logic [NLINE-1:0] flip;
    flip = prev ^ nxt;
    return {flip[3], prev[2] & ~nxt[2], flip[1], flip[0]};
  endfunction

  // Status view in loopback, built from control bits 3:0
  function automatic logic [BYTE_W-1:0] f_loop_view(input logic [3:0] c);
    return {c[B_OUT2], c[B_OUT1], c[B_DTR], c[B_RTS], 4'b0000};
  endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_q <= CTL_RST;
    else if (wr_i) ctl_q <= wdata_i & CTL_MASK;
  end

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] line_i,
  input  logic             clr_i,
  output logic [NLINE-1:0] ln_q,
  output logic [NLINE-1:0] dl_q,
  output logic [NLINE-1:0] dl_set
);

  assign dl_set = f_delta_set(ln_q, line_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q <= LINE_RST;
      dl_q <= '0;
    end else begin
      ln_q <= line_i;
      dl_q <= (clr_i ? '0 : dl_q) | dl_set;
    end
  end

endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ln_cts_i,
  input  logic              ln_dsr_i,
  input  logic              ln_dcd_i,
  input  logic              ln_ri_i,
  input  logic              ctl_wr_i,
  input  logic [BYTE_W-1:0] ctl_wdata_i,
  output logic [BYTE_W-1:0] ctl_rdata_o,
  input  logic              sts_rd_i,
  output logic [BYTE_W-1:0] sts_rdata_o,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              out1_o,
  output logic              out2_o,
  output logic              any_delta_o
);

  logic [BYTE_W-1:0] ctl_q;
  logic [NLINE-1:0]  line_raw, line_sync;
  logic [NLINE-1:0]  ln_q, dl_q, dl_set;
  logic              loop_on, rd_clear;

  assign line_raw = {ln_dcd_i, ln_ri_i, ln_dsr_i, ln_cts_i};

  mdm_sync #(.W(NLINE), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (line_raw),
    .q_o  (line_sync)
  );

  mdm_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ctl_wr_i),
    .wdata_i(ctl_wdata_i),
    .ctl_q  (ctl_q)
  );

  assign loop_on  = ctl_q[B_LOOP];
  assign rd_clear = sts_rd_i & ~loop_on;

  mdm_delta u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .line_i(line_sync),
    .clr_i (rd_clear),
    .ln_q  (ln_q),
    .dl_q  (dl_q),
    .dl_set(dl_set)
  );

  assign ctl_rdata_o = ctl_q;
  assign sts_rdata_o = loop_on ? f_loop_view(ctl_q[3:0]) : {ln_q, dl_q};
  assign rts_o       = ctl_q[B_RTS] & ~loop_on;
  assign dtr_o       = ctl_q[B_DTR] & ~loop_on;
  assign out1_o      = ctl_q[B_OUT1];
  assign out2_o      = ctl_q[B_OUT2];
  assign any_delta_o = |dl_q;

endmodule

// File: rtl/mdm_ctl_stat_chk.sv
module mdm_ctl_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sts_rd_i,
  input logic [7:0] ctl_rdata_o,
  input logic [7:0] sts_rdata_o,
  input logic       rts_o,
  input logic       dtr_o,
  input logic       any_delta_o,
  input logic [3:0] ln_q,
  input logic [3:0] dl_q,
  input logic [3:0] dl_set
);

  a_r2_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata_o[7:5] == 3'b000);

  a_r9_loop_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata_o[4] |-> (!rts_o && !dtr_o));

  a_r8_loop_delta_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata_o[4] |-> (sts_rdata_o[3:0] == 4'h0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_rd_i || ctl_rdata_o[4]) |=> (($past(dl_q) & ~dl_q) == 4'h0));

  a_r7_keep_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd_i && !ctl_rdata_o[4]) |=> (dl_q == $past(dl_set)));

  a_r4_cts_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_q[0] != $past(ln_q[0])) |-> dl_q[0]);

  a_r5_ri_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd_i && !ctl_rdata_o[4]) |=> (!dl_q[2] || $fell(ln_q[2])));

  a_r10_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata_o[4] |-> (any_delta_o == (sts_rdata_o[3:0] != 4'h0)));

endmodule

bind mdm_ctl_stat mdm_ctl_stat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sts_rd_i   (sts_rd_i),
  .ctl_rdata_o(ctl_rdata_o),
  .sts_rdata_o(sts_rdata_o),
  .rts_o      (rts_o),
  .dtr_o      (dtr_o),
  .any_delta_o(any_delta_o),
  .ln_q       (ln_q),
  .dl_q       (dl_q),
  .dl_set     (dl_set)
);

// File: tb/test_mdm_ctl_stat.sv
`timescale 1ns/1ps
module test_mdm_ctl_stat;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts = 1'b1, dsr = 1'b1, dcd = 1'b1, ri = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wd = 8'h00;
  logic       sts_rd = 1'b0;
  logic [7:0] ctl_rd, sts;
  logic       rts, dtr, out1, out2, anyd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model of held lines and deltas
  logic m_c = 1'b1, m_s = 1'b1, m_d = 1'b1, m_r = 1'b0;
  logic [3:0] m_dl = 4'h0;

  always #2.5 clk = ~clk;

  mdm_ctl_stat i_mdm_ctl_stat (
    .clk(clk), .rst_n(rst_n),
    .ln_cts_i(cts), .ln_dsr_i(dsr), .ln_dcd_i(dcd), .ln_ri_i(ri),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .ctl_rdata_o(ctl_rd),
    .sts_rd_i(sts_rd), .sts_rdata_o(sts),
    .rts_o(rts), .dtr_o(dtr), .out1_o(out1), .out2_o(out2),
    .any_delta_o(anyd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sts();
    return {m_d, m_r, m_s, m_c, m_dl};
  endfunction

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wd = v;
    @(negedge clk); ctl_wr = 1'b0; #1;
  endtask

  // Apply new line levels, wait out the three-edge latency, update model
  task automatic set_lines(input logic d, input logic r, input logic s, input logic c);
    @(negedge clk); dcd = d; ri = r; dsr = s; cts = c;
    repeat (3) @(negedge clk);
    #1;
    if (c != m_c) m_dl[0] = 1'b1;
    if (s != m_s) m_dl[1] = 1'b1;
    if (m_r && !r) m_dl[2] = 1'b1;
    if (d != m_d) m_dl[3] = 1'b1;
    m_c = c; m_s = s; m_d = d; m_r = r;
  endtask

  task automatic read_clear(input string tag);
    @(negedge clk); sts_rd = 1'b1; #1;
    chk({tag, " read value"}, sts, exp_sts());
    @(negedge clk); sts_rd = 1'b0; #1;
    m_dl = 4'h0;
    chk({tag, " after clear"}, sts, exp_sts());
    chk({tag, " any flag after clear"}, {7'd0, anyd}, 8'h00);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 control reset", ctl_rd, 8'h08);
    chk("R1 pins reset", {4'd0, out2, out1, rts, dtr}, 8'h08);
    chk("R1 status reset", sts, 8'hB0);
    chk("R1 any flag reset", {7'd0, anyd}, 8'h00);
  endtask

  task automatic t_ctl();
    ctl_write(8'hE7);
    chk("R2 upper bits masked", ctl_rd, 8'h07);
    chk("R2 pins 0x07", {4'd0, out2, out1, rts, dtr}, 8'h07);
    ctl_write(8'h0A);
    chk("R2 pins 0x0A", {4'd0, out2, out1, rts, dtr}, 8'h0A);
  endtask

  task automatic t_latency();
    @(negedge clk); cts = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk("R3 not yet visible after two edges", sts, 8'hB0);
    @(negedge clk); #1;
    m_c = 1'b0; m_dl[0] = 1'b1;
    chk("R3 visible after three edges with R4 cts delta", sts, exp_sts());
    chk("R10 any flag set", {7'd0, anyd}, 8'h01);
    repeat (4) @(negedge clk); #1;
    chk("R6 delta sticky", sts, exp_sts());
    read_clear("R6 cts");
  endtask

  task automatic t_lines();
    set_lines(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 dcd and dsr deltas", sts, exp_sts());
    read_clear("R4");
    set_lines(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 rising deltas", sts, exp_sts());
    read_clear("R4 rise");
  endtask

  task automatic t_ring();
    set_lines(m_d, 1'b1, m_s, m_c);
    chk("R5 ring rise no delta", sts, exp_sts());
    chk("R5 ring rise any flag low", {7'd0, anyd}, 8'h00);
    set_lines(m_d, 1'b0, m_s, m_c);
    chk("R5 ring fall delta", sts, exp_sts());
    read_clear("R5");
  endtask

  task automatic t_same_edge();
    set_lines(m_d, m_r, ~m_s, m_c);
    @(negedge clk); cts = ~m_c;
    @(negedge clk);
    @(negedge clk); sts_rd = 1'b1; #1;
    chk("R7 read value before edge", sts, exp_sts());
    @(negedge clk); sts_rd = 1'b0; #1;
    m_c = cts; m_dl = 4'b0001;
    chk("R7 new event survives clear", sts, exp_sts());
    read_clear("R7");
  endtask

  task automatic t_loop();
    set_lines(m_d, m_r, m_s, ~m_c);
    ctl_write(8'h1F);
    chk("R8 loop view all set", sts, 8'hF0);
    chk("R9 rts dtr low in loop", {4'd0, out2, out1, rts, dtr}, 8'h0C);
    chk("R10 any flag held in loop", {7'd0, anyd}, 8'h01);
    ctl_write(8'h15);
    chk("R8 loop view 0x15", sts, 8'h60);
    ctl_write(8'h1A);
    chk("R8 loop view 0x1A", sts, 8'h90);
    @(negedge clk); sts_rd = 1'b1;
    @(negedge clk); sts_rd = 1'b0;
    ctl_write(8'h08);
    chk("R8 loop read kept deltas", sts, exp_sts());
    read_clear("R8 exit");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctl();
    t_latency();
    t_lines();
    t_ring();
    t_same_edge();
    t_loop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule